// File: doc/BRIEF.md
# Cascadable Presettable Binary Counter

This block is a synchronous binary up-counter built from identical 4-bit stages. Each stage has a parallel load, two count enables and a terminal-count output. Each stage's terminal count feeds the gating enable of the stage above it. Chaining `STAGES` nibbles in this way gives one counter of `STAGES*4` bits. The low-active clear forces the whole count to zero at once. The clear's release is re-timed through a two-flop synchroniser, so the first counting edge after reset is well defined.

The two enables have different jobs. `enable_p` is shared by all stages and only permits counting. `enable_t` also gates the terminal-count output. The synchronous load takes priority over both enables. The terminal count is combinational from the registered count and `enable_t`, so it stays high for the whole cycle in which the count is all ones.

Top module: `cbc_chain`

## Requirements
- R1: While `clear_n` is low, `count` is all zeros and `tc` is low, without waiting for a clock edge, whatever `load_n`, the enables and `data` are.
- R2: After `clear_n` rises, the first two rising clock edges leave `count` at zero. The third rising edge is the first one that can load or count.
- R3: At a rising edge with `load_n` low, `count` takes the value of `data`, whatever the levels of `enable_p` and `enable_t`.
- R4: At a rising edge with `load_n` high and both enables high, `count` increases by one. It wraps from all ones to all zeros.
- R5: At a rising edge with `load_n` high and either enable low, `count` keeps its value.
- R6: `tc` is high exactly when `enable_t` is high and `count` is all ones. `enable_p` has no effect on it.
- R7: The wide count is the stages joined with stage 0 as bits 3:0. Carries pass across the nibble boundaries, so the width counts as one binary counter (for example 0x0F goes to 0x10).
- R8: `tc` follows a change of `enable_t` within the same clock cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clear_n | input | 1 | Asynchronous clear, active low, released synchronously |
| load_n | input | 1 | Synchronous parallel load, active low |
| enable_p | input | 1 | Count permit shared by all stages |
| enable_t | input | 1 | Count enable that also gates tc |
| data | input | STAGES*4 | Parallel load value |
| count | output | STAGES*4 | Current count, stage 0 in the low nibble |
| tc | output | 1 | Terminal count of the full width |

## Verification
The clocked assertions take for granted that `clear_n` is high and the release synchroniser has finished. The `$past` checks are only meaningful across edges where the count flops are out of reset. The stimulus changes every input on the falling edge, so the values seen at each rising edge are settled. `clear_n` is pulled low in the middle of a cycle only for the asynchronous checks. While clear is held, the clock keeps running, so the bench can show that loads and counts are ignored until the synchroniser lets go. `enable_t` is also toggled between edges, to show that `tc` responds without a clock.

// File: rtl/cbc_pkg.sv
package cbc_pkg;
  localparam int NIB_W = 4;
  localparam int SYNC_DEPTH = 2;
  typedef logic [NIB_W-1:0] nib_t;
endpackage

// File: rtl/cbc_rst_sync.sv
module cbc_rst_sync #(
  parameter int DEPTH = cbc_pkg::SYNC_DEPTH
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [DEPTH-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[DEPTH-2:0], 1'b1};
  end

  assign rst_n = chain_q[DEPTH-1];

  // once released, the chain only drops through the async clear
  assert_release_mono_R2: assert property (@(posedge clk) disable iff (!arst_n)
    $past(rst_n) |-> rst_n);
endmodule

// File: rtl/cbc_next.sv
module cbc_next
  import cbc_pkg::*;
(
  input  nib_t cur,
  input  nib_t data,
  input  logic load_n,
  input  logic en_p,
  input  logic en_t,
  output nib_t nxt
);
  always_comb begin
    if (!load_n)           nxt = data;
    else if (en_p && en_t) nxt = cur + nib_t'(1);
    else                   nxt = cur;
  end
endmodule

// File: rtl/cbc_stage.sv
module cbc_stage
  import cbc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic load_n,
  input  logic en_p,
  input  logic en_t,
  input  nib_t data,
  output nib_t count,
  output logic tc
);
  nib_t count_q;
  nib_t count_d;

  cbc_next i_next (
    .cur    (count_q),
    .data   (data),
    .load_n (load_n),
    .en_p   (en_p),
    .en_t   (en_t),
    .nxt    (count_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= count_d;
  end

  assign count = count_q;
  assign tc    = en_t & (&count_q);

  assert_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !load_n |=> (count_q == $past(data)));
  assert_incr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && en_p && en_t) |=> (count_q == nib_t'($past(count_q) + nib_t'(1))));
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && !(en_p && en_t)) |=> $stable(count_q));
endmodule

// File: rtl/cbc_chain.sv
module cbc_chain
  import cbc_pkg::*;
#(
  parameter int STAGES = 2,
  localparam int W = STAGES * NIB_W
) (
  input  logic         clk,
  input  logic         clear_n,
  input  logic         load_n,
  input  logic         enable_p,
  input  logic         enable_t,
  input  logic [W-1:0] data,
  output logic [W-1:0] count,
  output logic         tc
);
  logic rst_n;
  logic [STAGES:0] carry;

  cbc_rst_sync #(.DEPTH(SYNC_DEPTH)) i_sync (
    .clk    (clk),
    .arst_n (clear_n),
    .rst_n  (rst_n)
  );

  assign carry[0] = enable_t;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    cbc_stage i_stage (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_n (load_n),
      .en_p   (enable_p),
      .en_t   (carry[s]),
      .data   (data[s*NIB_W +: NIB_W]),
      .count  (count[s*NIB_W +: NIB_W]),
      .tc     (carry[s+1])
    );
  end

  assign tc = carry[STAGES];

  assert_clear_zero_R1: assert property (@(posedge clk)
    !clear_n |-> (count == '0 && !tc));
  assert_tc_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tc |-> (enable_t && count == '1));
  assert_wide_incr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && enable_p && enable_t) |=> (count == W'($past(count) + W'(1))));
endmodule

// File: tb/test_cbc_chain.sv
module test_cbc_chain;
  localparam int CLK_PERIOD = 10;
  localparam int STAGES = 2;
  localparam int W = STAGES * 4;
  localparam int unsigned MAXV = (1 << W) - 1;

  logic clk = 1'b0;
  logic clear_n = 1'b0;
  logic load_n = 1'b1;
  logic enable_p = 1'b0;
  logic enable_t = 1'b0;
  logic [W-1:0] data = '0;
  logic [W-1:0] count;
  logic tc;

  int n_run = 0;
  int n_fail = 0;
  int unsigned m = 0;
  int rel = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cbc_chain #(.STAGES(STAGES)) i_cbc_chain (
    .clk(clk), .clear_n(clear_n), .load_n(load_n), .enable_p(enable_p),
    .enable_t(enable_t), .data(data), .count(count), .tc(tc)
  );

  task automatic check(input string req, input int unsigned act, input int unsigned exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_out(input string req);
    check(req, count, m);
    check(req, tc, (enable_t && m == MAXV) ? 1 : 0);
  endtask

  task automatic step(input string req);
    @(posedge clk);
    if (!clear_n) begin m = 0; rel = 0; end
    else if (rel < 2) rel++;
    else if (!load_n) m = data;
    else if (enable_p && enable_t) m = (m + 1) & MAXV;
    @(negedge clk);
    check_out(req);
  endtask

  task automatic drive(input logic ld, input logic ep, input logic et, input int unsigned d);
    load_n = ld; enable_p = ep; enable_t = et; data = W'(d);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    check_out("R1");
    // R1: clock keeps running with load active while clear is held
    drive(0, 1, 1, 8'h3C);
    step("R1");
    step("R1");
    // R2: release, two edges stay zero, third edge loads
    clear_n = 1'b1;
    drive(0, 1, 1, 8'hA5);
    step("R2");
    step("R2");
    step("R3");
    // R4 counting
    drive(1, 1, 1, 0);
    for (int i = 0; i < 5; i++) step("R4");
    // R5 hold with each enable low
    drive(1, 0, 1, 0);
    for (int i = 0; i < 3; i++) step("R5");
    drive(1, 1, 0, 0);
    for (int i = 0; i < 3; i++) step("R5");
    // R7 nibble carry 0x0D..0x12
    drive(0, 1, 1, 8'h0D); step("R3");
    drive(1, 1, 1, 0);
    for (int i = 0; i < 5; i++) step("R7");
    // R3 load with both enables low
    drive(0, 0, 0, 8'hFD); step("R3");
    drive(1, 1, 1, 0);
    step("R4"); step("R4");
    // R6: at all ones, enable_p low leaves tc high
    check("R6", count, 8'hFF);
    enable_p = 1'b0; #1;
    check("R6", tc, 1);
    step("R6");
    // R8: tc follows enable_t mid-cycle
    enable_t = 1'b0; #1;
    check("R8", tc, 0);
    enable_t = 1'b1; #1;
    check("R8", tc, 1);
    enable_p = 1'b1;
    step("R4");
    check("R4", count, 0);
    // R1 mid-cycle clear
    drive(0, 1, 1, 8'h77); step("R3");
    clear_n = 1'b0; #1;
    check("R1", count, 0);
    check("R1", tc, 0);
    m = 0; rel = 0;
    drive(0, 0, 0, 8'hFF);
    step("R1");
    @(negedge clk); #1;
    check("R1", tc, 0);
    clear_n = 1'b1;
    drive(1, 1, 1, 0);
    step("R2"); step("R2"); step("R4");
    check("R2", count, 1);
    // mixed patterns
    for (int i = 0; i < 300; i++) begin
      drive(($urandom % 8) != 0, ($urandom % 4) != 0, ($urandom % 4) != 0,
            (($urandom % 3) == 0) ? 8'hFE : $urandom % 256);
      step("R4");
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule